// File: doc/BRIEF.md
# Debounced Low-Power Wakeup Detector

This block runs from an always-on clock while the rest of the system sleeps. It monitors three board inputs: a push button whose line idles high and reads low while pressed, a lid switch that reads high when the lid is open, and a line that reads high while external AC power is present. Each input is resynchronised and then qualified by its own debounce state machine, which has a programmable 16-bit hold time. A press is a falling edge on the button line. An opening is a rising edge on the lid line. AC presence is a high level. In each case the input must then stay at the active level for long enough.

Qualification is armed only while a control enable bit is set. A qualified event raises two sticky status bits: a low-power-event flag and a wakeup flag. It also drives a wakeup output that mirrors the wakeup flag. Software writes a one to a status bit to clear it. A small register port gives access to the enable bit, the three hold times and the status bits. It has a write strobe, an address, write data and combinational read data.

Top module: `wake_detect`

## Requirements
- R1: After reset the control register (address 0) reads 0, each hold-time register (addresses 1 = button, 2 = lid, 3 = AC) reads the default 16, the status register (address 4) reads 0, and `wake_o` is low.
- R2: Writes to the control register (bit 0 = enable) and to the hold-time registers read back unchanged. Unmapped addresses read 0.
- R3: With enable set, a falling edge on `btn_n_i` followed by a low hold of at least T+2 cycles (T = button hold time) sets status bit 0 (event flag) and bit 1 (wakeup flag), so the status register reads 3, and drives `wake_o` high.
- R4: With enable set, a rising edge on `lid_i` held high for at least T+2 cycles raises both status bits and `wake_o`.
- R5: With enable set, `ac_i` high for at least T+2 cycles raises both status bits and `wake_o`. This input needs no edge.
- R6: A hold of exactly T or exactly T+1 cycles produces no event.
- R7: An input that returns to its idle level before qualifying produces no event.
- R8: With enable clear, no input activity sets a status bit or raises `wake_o`.
- R9: Writing status with a one in a bit position clears that bit. A zero leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: Status bits and `wake_o` stay set after the input returns to idle, until they are cleared.
- R11: Clearing enable returns every state machine to idle. A held button therefore needs a fresh falling edge after enable is set again.
- R12: A hold time of 0 behaves as 1: a 2-cycle hold does not qualify and a 3-cycle hold does.
- R13: An edge in the wrong direction does not start qualification. For example, a lid that was already open when enable was set, and then closes and stays closed, produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_n_i | input | 1 | Button line, idles high, low while pressed |
| lid_i | input | 1 | Lid switch, high when open |
| ac_i | input | 1 | AC-present line |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| wake_o | output | 1 | Wakeup request, follows the wakeup status bit |

## Verification
The bench drives holds of exactly T, T+1 and T+2 cycles. A machine off by one cycle in either direction would raise a wakeup one hold length early or miss one that is due. It also checks directionality: it drives a lid that opens while the block is disarmed and then closes, and a button held across a disable/enable pulse. A design that used levels instead of edges, or that kept its debounce state when disabled, would raise a false wakeup. It writes single-bit and zero-valued status clears, which reveal a design that clears the whole register or ignores the bit mask. It also programs a hold time of zero, which a design without the floor of one would qualify a cycle early.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned TMR_W     = 16;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 16;

    // Source index: 0 button, 1 lid, 2 AC
    localparam logic [NUM_SRC-1:0] SRC_ACTIVE_HIGH = 3'b110;
    localparam logic [NUM_SRC-1:0] SRC_EDGE_START  = 3'b011;
    localparam logic [NUM_SRC-1:0] SRC_IDLE_LEVEL  = ~SRC_ACTIVE_HIGH;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_TMR0 = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

    localparam logic [TMR_W-1:0] TMR_DEFAULT = 16'd16;

    typedef enum logic [1:0] {
        DB_IDLE  = 2'd0,
        DB_COUNT = 2'd1,
        DB_ARMED = 2'd2
    } db_state_e;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int unsigned     W         = 3,
    parameter logic [W-1:0]    RST_LEVEL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = raw_i;
        sync_d.cur  = sync_q.meta;
        sync_d.prev = sync_q.cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '{meta: RST_LEVEL, cur: RST_LEVEL, prev: RST_LEVEL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cur_o  = sync_q.cur;
    assign prev_o = sync_q.prev;

endmodule

// File: rtl/wake_debounce.sv
module wake_debounce
    import wake_pkg::*;
#(
    parameter int unsigned TW          = 16,
    parameter bit          ACTIVE_HIGH = 1'b1,
    parameter bit          EDGE_START  = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          cur_i,
    input  logic          prev_i,
    input  logic [TW-1:0] hold_i,
    output logic          evt_o,
    output logic          busy_o
);

    typedef struct packed {
        db_state_e     st;
        logic [TW-1:0] cnt;
    } db_t;

    db_t db_d, db_q;

    logic          active;
    logic          start;
    logic [TW-1:0] hold_eff;

    always_comb begin
        active   = (cur_i == ACTIVE_HIGH);
        start    = EDGE_START ? (active && (prev_i != cur_i)) : active;
        hold_eff = (hold_i == '0) ? TW'(1) : hold_i;

        db_d  = db_q;
        evt_o = 1'b0;
        if (!en_i) begin
            db_d.st  = DB_IDLE;
            db_d.cnt = '0;
        end else begin
            unique case (db_q.st)
                DB_IDLE: begin
                    if (start) begin
                        db_d.st  = DB_COUNT;
                        db_d.cnt = TW'(1);
                    end
                end
                DB_COUNT: begin
                    if (!active) begin
                        db_d.st = DB_IDLE;
                    end else if (db_q.cnt >= hold_eff) begin
                        db_d.st = DB_ARMED;
                    end else begin
                        db_d.cnt = db_q.cnt + TW'(1);
                    end
                end
                DB_ARMED: begin
                    db_d.st = DB_IDLE;
                    evt_o   = active;
                end
                default: db_d.st = DB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            db_q <= '{st: DB_IDLE, cnt: '0};
        end else begin
            db_q <= db_d;
        end
    end

    assign busy_o = (db_q.st != DB_IDLE);

endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int unsigned N  = NUM_SRC,
    parameter int unsigned TW = TMR_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic                 evt_i,
    output logic                 en_o,
    output logic [N-1:0][TW-1:0] hold_o,
    output logic [DW-1:0]        rdata_o,
    output logic                 wake_o
);

    typedef struct packed {
        logic                 en;
        logic [N-1:0][TW-1:0] hold;
        logic                 st_evt;
        logic                 st_wake;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_i) begin
            if (addr_i == ADDR_CTRL) begin
                rg_d.en = wdata_i[0];
            end
            if (addr_i == ADDR_STAT) begin
                if (wdata_i[0]) rg_d.st_evt  = 1'b0;
                if (wdata_i[1]) rg_d.st_wake = 1'b0;
            end
            for (int i = 0; i < N; i++) begin
                if (addr_i == AW'(ADDR_TMR0 + AW'(i))) begin
                    rg_d.hold[i] = wdata_i[TW-1:0];
                end
            end
        end
        if (evt_i) begin
            rg_d.st_evt  = 1'b1;
            rg_d.st_wake = 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o[0] = rg_q.en;
        end
        if (addr_i == ADDR_STAT) begin
            rdata_o[1:0] = {rg_q.st_wake, rg_q.st_evt};
        end
        for (int i = 0; i < N; i++) begin
            if (addr_i == AW'(ADDR_TMR0 + AW'(i))) begin
                rdata_o[TW-1:0] = rg_q.hold[i];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q.en      <= 1'b0;
            rg_q.hold    <= {N{TMR_DEFAULT}};
            rg_q.st_evt  <= 1'b0;
            rg_q.st_wake <= 1'b0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign en_o   = rg_q.en;
    assign hold_o = rg_q.hold;
    assign wake_o = rg_q.st_wake;

endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import wake_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              btn_n_i,
    input  logic              lid_i,
    input  logic              ac_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              wake_o
);

    logic [NUM_SRC-1:0]            raw;
    logic [NUM_SRC-1:0]            cur;
    logic [NUM_SRC-1:0]            prev;
    logic [NUM_SRC-1:0]            src_evt;
    logic [NUM_SRC-1:0]            src_busy;
    logic [NUM_SRC-1:0][TMR_W-1:0] hold;
    logic                          en_q;
    logic                          any_evt;

    assign raw     = {ac_i, lid_i, btn_n_i};
    assign any_evt = |src_evt;

    wake_sync #(
        .W         (NUM_SRC),
        .RST_LEVEL (SRC_IDLE_LEVEL)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (raw),
        .cur_o  (cur),
        .prev_o (prev)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        wake_debounce #(
            .TW          (TMR_W),
            .ACTIVE_HIGH (SRC_ACTIVE_HIGH[g]),
            .EDGE_START  (SRC_EDGE_START[g])
        ) u_db (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (en_q),
            .cur_i  (cur[g]),
            .prev_i (prev[g]),
            .hold_i (hold[g]),
            .evt_o  (src_evt[g]),
            .busy_o (src_busy[g])
        );
    end

    wake_regs #(
        .N  (NUM_SRC),
        .TW (TMR_W),
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .evt_i   (any_evt),
        .en_o    (en_q),
        .hold_o  (hold),
        .rdata_o (reg_rdata_o),
        .wake_o  (wake_o)
    );

endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk
    import wake_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               en_q,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [NUM_SRC-1:0] src_busy,
    input logic               reg_wr_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic               wake_o
);

    logic clr_wake;
    assign clr_wake = reg_wr_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[1];

    a_r3_event_raises_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|src_evt) |=> wake_o);

    a_r8_disabled_no_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_q && !wake_o) |=> !wake_o);

    a_r9_clear_drops_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wake && !(|src_evt)) |=> !wake_o);

    a_r10_wake_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_o && !clr_wake) |=> wake_o);

    a_r11_disable_forces_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |=> (src_busy == '0));

endmodule

bind wake_detect wake_detect_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_q        (en_q),
    .src_evt     (src_evt),
    .src_busy    (src_busy),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .wake_o      (wake_o)
);

// File: tb/wake_detect_tb_top.sv
module wake_detect_tb_top;
    import wake_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              btn_n = 1'b1;
    logic              lid = 1'b0;
    logic              ac = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = ADDR_STAT;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              wake;

    always #5 clk = ~clk;

    wake_detect dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .btn_n_i     (btn_n),
        .lid_i       (lid),
        .ac_i        (ac),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .wake_o      (wake)
    );

    typedef struct {
        string             req;
        logic [DATA_W-1:0] exp_data;
        logic              exp_wake;
    } item_t;

    item_t q_exp[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    event  chk_ev;
    event  mon_done;

    // Monitor: pops the expected item and compares at the next falling edge
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk);
            begin
                item_t it;
                it = q_exp.pop_front();
                n_vec++;
                if (rdata !== it.exp_data || wake !== it.exp_wake) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h wake=%b expected rdata=%h wake=%b",
                             it.req, rdata, wake, it.exp_data, it.exp_wake);
                end
            end
            -> mon_done;
        end
    end

    task automatic expect_rd(input string req, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input logic w);
        item_t it;
        addr = a;
        it.req = req; it.exp_data = d; it.exp_wake = w;
        q_exp.push_back(it);
        -> chk_ev;
        @(mon_done);
        addr = ADDR_STAT;
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = ADDR_STAT; wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int h);
        @(negedge clk); btn_n = 1'b0;
        idle(h);
        btn_n = 1'b1;
        idle(30);
    endtask

    task automatic open_lid(input int h);
        @(negedge clk); lid = 1'b1;
        idle(h);
        lid = 1'b0;
        idle(30);
    endtask

    task automatic ac_pulse(input int h);
        @(negedge clk); ac = 1'b1;
        idle(h);
        ac = 1'b0;
        idle(30);
    endtask

    task automatic clear_all();
        reg_write(ADDR_STAT, 16'h3);
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        expect_rd("R1 ctrl", ADDR_CTRL, 16'h0, 1'b0);
        expect_rd("R1 hold btn", 3'd1, 16'd16, 1'b0);
        expect_rd("R1 hold lid", 3'd2, 16'd16, 1'b0);
        expect_rd("R1 hold ac", 3'd3, 16'd16, 1'b0);
        expect_rd("R1 status", ADDR_STAT, 16'h0, 1'b0);

        // R2 programming and read-back
        reg_write(3'd1, 16'd5);
        reg_write(3'd2, 16'd5);
        reg_write(3'd3, 16'd5);
        reg_write(ADDR_CTRL, 16'h1);
        expect_rd("R2 ctrl", ADDR_CTRL, 16'h1, 1'b0);
        expect_rd("R2 hold btn", 3'd1, 16'd5, 1'b0);
        expect_rd("R2 hold ac", 3'd3, 16'd5, 1'b0);
        expect_rd("R2 unmapped", 3'd6, 16'h0, 1'b0);

        // R3 button press, R10 stays set after release
        press(20);
        expect_rd("R3 R10 btn event sticky", ADDR_STAT, 16'h3, 1'b1);
        // R9 partial and zero clears
        reg_write(ADDR_STAT, 16'h1);
        expect_rd("R9 clear bit0 only", ADDR_STAT, 16'h2, 1'b1);
        reg_write(ADDR_STAT, 16'h0);
        expect_rd("R9 zero write no effect", ADDR_STAT, 16'h2, 1'b1);
        reg_write(ADDR_STAT, 16'h2);
        expect_rd("R9 clear bit1", ADDR_STAT, 16'h0, 1'b0);

        // R6 off-by-one boundaries, T = 5
        press(5);
        expect_rd("R6 hold T", ADDR_STAT, 16'h0, 1'b0);
        press(6);
        expect_rd("R6 hold T+1", ADDR_STAT, 16'h0, 1'b0);
        press(7);
        expect_rd("R6 hold T+2", ADDR_STAT, 16'h3, 1'b1);
        clear_all();

        // R7 early release
        press(3);
        expect_rd("R7 btn short", ADDR_STAT, 16'h0, 1'b0);
        ac_pulse(3);
        expect_rd("R7 ac short", ADDR_STAT, 16'h0, 1'b0);

        // R4 lid opening
        open_lid(20);
        expect_rd("R4 lid event", ADDR_STAT, 16'h3, 1'b1);
        clear_all();

        // R5 AC level
        ac_pulse(20);
        expect_rd("R5 ac event", ADDR_STAT, 16'h3, 1'b1);
        clear_all();

        // R13 lid opens while disarmed, then closes while armed
        reg_write(ADDR_CTRL, 16'h0);
        lid = 1'b1;
        idle(20);
        reg_write(ADDR_CTRL, 16'h1);
        idle(20);
        lid = 1'b0;
        idle(30);
        expect_rd("R13 wrong-direction edge", ADDR_STAT, 16'h0, 1'b0);

        // R8 disabled
        reg_write(ADDR_CTRL, 16'h0);
        press(20);
        open_lid(20);
        ac_pulse(20);
        expect_rd("R8 disabled no event", ADDR_STAT, 16'h0, 1'b0);

        // R11 disable pulse during debounce
        reg_write(ADDR_CTRL, 16'h1);
        @(negedge clk); btn_n = 1'b0;
        idle(4);
        reg_write(ADDR_CTRL, 16'h0);
        reg_write(ADDR_CTRL, 16'h1);
        idle(25);
        expect_rd("R11 held across disable", ADDR_STAT, 16'h0, 1'b0);
        btn_n = 1'b1;
        idle(30);

        // R12 zero hold time
        reg_write(3'd1, 16'd0);
        press(2);
        expect_rd("R12 zero hold 2 cycles", ADDR_STAT, 16'h0, 1'b0);
        press(3);
        expect_rd("R12 zero hold 3 cycles", ADDR_STAT, 16'h3, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule